// File: doc/BRIEF.md
# Nibble-Bus Port Expander

This block is a slave on a shared 4-bit bidirectional bus. It turns that bus into four independent 4-bit I/O ports. A host selects the block with an active-low select line. It puts an instruction nibble on the bus and pulls the PROG strobe low. The instruction carries a 2-bit opcode and a 2-bit port index. For a write, the host then places a data nibble on the bus, and the block stores it into the chosen port when PROG returns high. For a read, the block drives the chosen port's input pins back onto the bus for as long as PROG stays low.

PROG and the select line arrive without a clock. Inside the block, each passes through a two-flop synchronizer to the system clock, and its edges are taken from the synchronized copies. The bus drive enable is the only exception. It is gated directly by the raw PROG and select pins, so the block releases the shared bus at once. When the select line is high, the block neither acts on PROG nor drives the bus, so several expanders can hang on one bus.

Top module: `nibble_port_expander`

## Requirements
- R1: After reset every port output register is 0, every port direction is input (`port_dir` bit = 0), and `bus_oe` is 0.
- R2: The instruction is sampled when the synchronized PROG falls while the select is low. Bus bits 1:0 give the port index k, and port k occupies `port_out`/`port_in` bits 4k+3:4k. Bits 3:2 give the opcode: 00 is read and 01 is write.
- R3: In a write, the nibble present on the bus when the synchronized PROG rises is stored into port k, and `port_dir[k]` becomes 1. The other ports do not change.
- R4: After a read instruction and while PROG and the select stay low, `bus_oe` is 1 and `bus_out` follows the live `port_in` nibble of port k.
- R5: A read sets `port_dir[k]` to 0 and leaves the stored output value of port k unchanged.
- R6: `bus_oe` falls in the same instant that the PROG pin goes high or the select pin goes high, with no clock edge needed.
- R7: While the select is high, PROG activity changes no port and `bus_oe` stays 0.
- R8: Opcodes 10 and 11 are accepted, change no port value or direction, and never drive the bus.
- R9: A write commits only if the synchronized select is still low when the PROG rise is seen. If the select goes high before the rise or together with it, the data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| prog | input | 1 | Instruction/data strobe, asynchronous |
| bus_in | input | 4 | Value seen on the shared nibble bus |
| bus_out | output | 4 | Nibble the block drives when enabled (0 otherwise) |
| bus_oe | output | 1 | Drive enable for the shared bus |
| port_in | input | 16 | Pin values of the four ports, port k at bits 4k+3:4k |
| port_out | output | 16 | Output registers of the four ports |
| port_dir | output | 4 | Per-port direction, 1 = output |

## Verification
Two events can land on the same clock. A write's commit is triggered by the PROG rise, and its abort is triggered by the select rising. The bench raises both pins at the same instant, so the two synchronizers deliver them on the same edge. It then checks that the target port keeps its old value and direction. A second case releases the select several cycles before PROG, to check that the early abort also discards the data. The release of the bus enable on a read is judged a nanosecond after the pin change, before any clock edge.

// File: rtl/npx_pkg.sv
package npx_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    OPC_READ  = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_SPARE2 = 2'b10,
    OPC_SPARE3 = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RD   = 2'b01,
    ST_WR   = 2'b10,
    ST_HOLD = 2'b11
  } npx_st_e;
endpackage

// File: rtl/npx_sync.sv
module npx_sync #(
  parameter int       W       = 1,
  parameter int       STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/npx_ctrl.sv
module npx_ctrl
  import npx_pkg::*;
#(
  parameter int NPORT = 4,
  localparam int IW   = $clog2(NPORT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_s,
  input  logic          cs_s,
  input  logic [NIB_W-1:0] bus_in,
  output logic          rd_go,
  output logic          wr_go,
  output logic [IW-1:0] sel_idx,
  output logic          rd_active
);
  npx_st_e      st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          prog_q;
  logic          fall, rise;
  opc_e          opc;

  assign fall = prog_q & ~prog_s;
  assign rise = ~prog_q & prog_s;
  assign opc  = opc_e'(bus_in[NIB_W-1:NIB_W-2]);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    rd_go = 1'b0;
    wr_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall && !cs_s) begin
          idx_d = bus_in[IW-1:0];
          unique case (opc)
            OPC_READ:  begin st_d = ST_RD; rd_go = 1'b1; end
            OPC_WRITE: st_d = ST_WR;
            default:   st_d = ST_HOLD;
          endcase
        end
      end
      ST_RD:   if (rise || cs_s) st_d = ST_IDLE;
      ST_WR: begin
        if (cs_s) st_d = ST_IDLE;
        else if (rise) begin
          wr_go = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_HOLD: if (rise || cs_s) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      prog_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      prog_q <= prog_s;
    end
  end

  assign sel_idx   = rd_go ? bus_in[IW-1:0] : idx_q;
  assign rd_active = (st_q == ST_RD);

  // spare opcodes: the holding state never issues a port update (R8)
  p_hold_is_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> (!rd_go && !wr_go));
endmodule

// File: rtl/npx_port_bank.sv
module npx_port_bank
  import npx_pkg::*;
#(
  parameter int NPORT = 4,
  localparam int IW   = $clog2(NPORT),
  localparam int PW   = NPORT * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic             wr_go,
  input  logic [IW-1:0]    sel_idx,
  input  logic [NIB_W-1:0] wdata,
  output logic [PW-1:0]    port_out,
  output logic [NPORT-1:0] port_dir
);
  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      logic             hit;
      logic             val_en, dir_en;
      logic [NIB_W-1:0] val_q;
      logic             dir_q, dir_d;

      assign hit    = (sel_idx == IW'(g));
      assign val_en = wr_go & hit;
      assign dir_en = (wr_go | rd_go) & hit;
      assign dir_d  = wr_go;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (val_en) val_q <= wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (dir_en) dir_q <= dir_d;
      end

      assign port_out[g*NIB_W +: NIB_W] = val_q;
      assign port_dir[g]                = dir_q;
    end
  endgenerate

  // only one port can change direction per clock (R2)
  p_one_port_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_dir ^ $past(port_dir)) <= 1);

  // output values only move after a committed write (R3)
  p_out_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> $past(wr_go));
endmodule

// File: rtl/nibble_port_expander.sv
module nibble_port_expander
  import npx_pkg::*;
#(
  parameter int NPORT = 4,
  localparam int IW   = $clog2(NPORT),
  localparam int PW   = NPORT * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             prog,
  input  logic [NIB_W-1:0] bus_in,
  output logic [NIB_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic [PW-1:0]    port_in,
  output logic [PW-1:0]    port_out,
  output logic [NPORT-1:0] port_dir
);
  logic             rst_sn;
  logic [1:0]       strobe_s;
  logic             prog_s, cs_s;
  logic             rd_go, wr_go, rd_active;
  logic [IW-1:0]    sel_idx;
  logic [NIB_W-1:0] rd_nib;

  // reset: asserted at once, released on a clock edge
  npx_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_async(1'b1), .q_sync(rst_sn));

  npx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_strobe_sync (
    .clk(clk), .rst_n(rst_sn), .d_async({prog, cs_n}), .q_sync(strobe_s));

  assign prog_s = strobe_s[1];
  assign cs_s   = strobe_s[0];

  npx_ctrl #(.NPORT(NPORT)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .prog_s(prog_s), .cs_s(cs_s), .bus_in(bus_in),
    .rd_go(rd_go), .wr_go(wr_go), .sel_idx(sel_idx), .rd_active(rd_active));

  npx_port_bank #(.NPORT(NPORT)) u_bank (
    .clk(clk), .rst_n(rst_sn), .rd_go(rd_go), .wr_go(wr_go), .sel_idx(sel_idx),
    .wdata(bus_in), .port_out(port_out), .port_dir(port_dir));

  always_comb begin
    rd_nib = '0;
    for (int k = 0; k < NPORT; k++)
      if (sel_idx == IW'(k)) rd_nib = port_in[k*NIB_W +: NIB_W];
  end

  // raw pins gate the enable so the bus is released without waiting a clock
  assign bus_oe  = rd_active & ~prog & ~cs_n & rst_sn;
  assign bus_out = bus_oe ? rd_nib : '0;

  // a port being read back has already been turned to input (R5)
  p_rd_port_is_input_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_active |-> !port_dir[sel_idx]);

  // no direction change unless the block was selected one clock earlier (R7)
  p_dir_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(port_dir) |-> !$past(cs_s));
endmodule

// File: tb/nibble_port_expander_tb_top.sv
`timescale 1ns/1ps
module nibble_port_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, prog;
  logic [3:0]  bus_in, bus_out;
  logic        bus_oe;
  logic [15:0] port_in, port_out;
  logic [3:0]  port_dir;

  int total = 0;
  int bad   = 0;
  logic [3:0] m_val [4];
  logic       m_dir [4];

  always #2.5 clk = ~clk;

  nibble_port_expander dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prog(prog), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .port_in(port_in),
    .port_out(port_out), .port_dir(port_dir));

  function automatic logic [15:0] exp_out();
    logic [15:0] v;
    for (int k = 0; k < 4; k++) v[k*4 +: 4] = m_val[k];
    return v;
  endfunction

  function automatic logic [3:0] exp_dir();
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = m_dir[k];
    return v;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_ports(string req);
    check(req, port_out, exp_out());
    check(req, {12'h0, port_dir}, {12'h0, exp_dir()});
  endtask

  // select_low=0 keeps select high for the whole cycle (ignored access)
  task automatic do_write(int idx, logic [3:0] d, bit select_low, int cs_mode);
    if (select_low) cs_n = 1'b0;
    cyc(3);
    bus_in = {2'b01, 2'(idx)};
    prog = 1'b0;
    cyc(6);
    bus_in = d;
    cyc(3);
    if (cs_mode == 1) begin           // select drops with the PROG rise
      prog = 1'b1; cs_n = 1'b1;
    end else if (cs_mode == 2) begin  // select drops early
      cs_n = 1'b1; cyc(6); prog = 1'b1;
    end else begin
      prog = 1'b1;
    end
    cyc(6);
    cs_n = 1'b1;
    bus_in = 4'h0;
    cyc(3);
    if (select_low && cs_mode == 0) begin
      m_val[idx] = d;
      m_dir[idx] = 1'b1;
    end
  endtask

  task automatic do_read(int idx, bit select_low, string req);
    if (select_low) cs_n = 1'b0;
    cyc(3);
    bus_in = {2'b00, 2'(idx)};
    prog = 1'b0;
    cyc(6);
    bus_in = 4'h0;
    if (select_low) begin
      m_dir[idx] = 1'b0;
      check({req, "/R4 oe"}, {15'h0, bus_oe}, 16'h1);
      check({req, "/R4 data"}, {12'h0, bus_out}, {12'h0, port_in[idx*4 +: 4]});
      port_in[idx*4 +: 4] = ~port_in[idx*4 +: 4];
      #1;
      check("R4 live pins", {12'h0, bus_out}, {12'h0, port_in[idx*4 +: 4]});
      cyc(1);
      check_ports("R5 read turns port to input");
      prog = 1'b1;
      #1;
      check("R6 release on PROG rise", {15'h0, bus_oe}, 16'h0);
    end else begin
      check("R7 no drive while unselected", {15'h0, bus_oe}, 16'h0);
      prog = 1'b1;
    end
    cyc(6);
    cs_n = 1'b1;
    cyc(3);
  endtask

  task automatic do_spare(int idx, bit op3);
    cs_n = 1'b0;
    cyc(3);
    bus_in = {1'b1, op3, 2'(idx)};
    prog = 1'b0;
    cyc(6);
    bus_in = 4'h5;
    cyc(3);
    check("R8 spare opcode no drive", {15'h0, bus_oe}, 16'h0);
    prog = 1'b1;
    cyc(6);
    cs_n = 1'b1;
    bus_in = 4'h0;
    cyc(3);
    check_ports("R8 spare opcode no change");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h1a2b3c4d);
    rst_n = 1'b0; cs_n = 1'b1; prog = 1'b1; bus_in = 4'h0; port_in = 16'hA5C3;
    for (int k = 0; k < 4; k++) begin m_val[k] = 4'h0; m_dir[k] = 1'b0; end
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    check("R1 reset out", port_out, 16'h0);
    check("R1 reset dir", {12'h0, port_dir}, 16'h0);
    check("R1 reset oe", {15'h0, bus_oe}, 16'h0);

    // directed: write each port, index order places nibbles (R2, R3)
    do_write(0, 4'h9, 1, 0); check_ports("R3 write port 0");
    do_write(3, 4'hF, 1, 0); check_ports("R2 index 3 highest nibble");
    do_write(1, 4'h6, 1, 0); check_ports("R3 write port 1");
    do_write(2, 4'h0, 1, 0); check_ports("R3 write zero port 2");
    // read keeps value, flips direction (R5)
    do_read(3, 1, "R5");
    check_ports("R5 value kept after read");
    // select release on a read drops the enable at once (R6)
    cs_n = 1'b0; cyc(3); bus_in = 4'h1; prog = 1'b0; cyc(6);
    check("R4 oe before select release", {15'h0, bus_oe}, 16'h1);
    cs_n = 1'b1; #1;
    check("R6 release on select rise", {15'h0, bus_oe}, 16'h0);
    cyc(4); prog = 1'b1; cyc(6); m_dir[1] = 1'b0;
    check_ports("R5 port 1 input after read");
    // unselected accesses (R7)
    do_write(2, 4'hB, 0, 0); check_ports("R7 write ignored when unselected");
    do_read(0, 0, "R7");
    check_ports("R7 read ignored when unselected");
    // spare opcodes (R8)
    do_spare(0, 1'b0);
    do_spare(2, 1'b1);
    // select rises together with PROG, and before it (R9)
    do_write(0, 4'h3, 1, 1); check_ports("R9 simultaneous select release drops write");
    do_write(2, 4'hC, 1, 2); check_ports("R9 early select release drops write");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int idx;
      r = $urandom();
      idx = int'(r[1:0]);
      port_in = 16'($urandom());
      unique case (r[4:2])
        3'd0, 3'd1, 3'd2: begin do_write(idx, 4'(r[11:8]), 1, 0); check_ports("R3 random write"); end
        3'd3, 3'd4:       begin do_read(idx, 1, "R4 random"); check_ports("R5 random read"); end
        3'd5:             begin do_spare(idx, r[12]); end
        3'd6:             begin do_write(idx, 4'(r[11:8]), 1, int'(r[13]) + 1); check_ports("R9 random abort"); end
        default:          begin do_write(idx, 4'(r[11:8]), 0, 0); check_ports("R7 random unselected"); end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule